// File: doc/BRIEF.md
# Frame Release Controller for Transmit and Receive FIFOs

This block sits beside the two packet FIFOs of an Ethernet-style MAC and decides when a buffered frame may begin to leave its FIFO. On the transmit side, a released frame starts draining toward the line. On the receive side, a released frame starts draining toward the DMA engine. Each direction has its own control register. That register sets the direction's mode, either whole-frame buffering or early release at a byte threshold, along with a DMA enable and a self-clearing DMA start. The transmit register has one more option that lets a second frame be released while the first is still draining.

The FIFOs report three things to the block: the byte count of the frame waiting at the head, whether that frame's last byte is already stored, and when a frame being drained is finished. The block answers with a one-cycle release strobe per direction. It also watches the line side of the transmit FIFO and the write side of the receive FIFO, and emits one-cycle error pulses for a transmit underflow or a receive overflow. All outputs are registered. Every effect of an input sampled at a clock edge appears right after that edge.

Top module: `frc_release_ctrl`

## Requirements
- R1: While reset is high and right after it, all four event outputs are 0 and both control readbacks are 0.
- R2: Transmit readback shows bit 30 (DMA enable), bits 10:8 (threshold code), bit 2 (next-frame option) and bit 1 (whole-frame mode) as written, with all other bits 0. Receive readback shows bit 30, bits 5:4 (threshold code) and bit 1 as written, with all other bits 0.
- R3: Writing bit 31 (DMA start) as 1 makes it read 1 right after the write and 0 one cycle later.
- R4: A direction only releases once it is running. It starts running on a write with bits 31 and 30 both set. It stays running through later writes that keep bit 30 set, and stops on a write with bit 30 clear.
- R5: In transmit whole-frame mode (bit 1 = 1), a release needs the head frame's end to be stored, whatever the byte count.
- R6: In transmit threshold mode, threshold codes 0, 1, 2 and 3 mean 64, 128, 192 and 256 bytes, and codes 4 to 7 also mean 256. A release happens when the head count reaches the threshold.
- R7: In threshold mode, on either side, a stored frame end releases the frame even when its count is below the threshold.
- R8: With the transmit next-frame bit clear, at most one transmit frame is in flight. With it set, two may be in flight. A frame-done report frees a slot from the following cycle on.
- R9: In receive whole-frame mode (bit 1 = 1), a release needs the head frame's end to be stored.
- R10: In receive threshold mode, codes 0, 1, 2 and 3 mean 32, 64, 96 and 128 bytes.
- R11: The receive side has one frame in flight. A new release waits until the cycle after the frame-done report.
- R12: A transmit underflow pulse follows a cycle in which the line requests data from an empty transmit FIFO, a frame is in flight, and that frame does not end in the same cycle.
- R13: A receive overflow pulse follows a cycle in which a write meets a full receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_ctl_we | input | 1 | Transmit control register write strobe |
| tx_ctl_wdata | input | 32 | Transmit control write data |
| tx_ctl_rdata | output | 32 | Transmit control readback |
| rx_ctl_we | input | 1 | Receive control register write strobe |
| rx_ctl_wdata | input | 32 | Receive control write data |
| rx_ctl_rdata | output | 32 | Receive control readback |
| tx_head_level | input | LVL_W | Bytes of the unreleased transmit head frame |
| tx_head_eof | input | 1 | Transmit head frame fully stored |
| tx_frame_done | input | 1 | A transmit frame in flight has finished draining |
| tx_rd_req | input | 1 | Line side requests a transmit byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_release | output | 1 | Transmit release strobe |
| tx_underflow | output | 1 | Transmit underflow event |
| rx_head_level | input | LVL_W | Bytes of the unreleased receive head frame |
| rx_head_eof | input | 1 | Receive head frame fully stored |
| rx_frame_done | input | 1 | Receive frame in flight has finished draining |
| rx_wr | input | 1 | MAC writes a receive byte |
| rx_full | input | 1 | Receive FIFO full |
| rx_release | output | 1 | Receive release strobe |
| rx_overflow | output | 1 | Receive overflow event |

## Verification
A wrong in-flight count on the transmit side shows up within one cycle. Either a second release strobe appears where the next-frame option forbids one, or an expected release goes missing after a frame-done report. A stale running flag or threshold field shows up on the first frame presented after the faulty write: the release either comes early at a count below the threshold or never arrives. A start bit that fails to clear is visible at the readback one cycle after the write. Error pulses are compared cycle by cycle against the request and status inputs that should cause them.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int REG_W       = 32;
  localparam int THR_W       = 9;
  localparam int TX_UNIT     = 64;
  localparam int RX_UNIT     = 32;
  localparam int TX_MAX_CODE = 3;
  // bit positions decoded by the control register slices
  localparam int B_START = 31;
  localparam int B_EN    = 30;
  localparam int B_SF    = 1;
  localparam int B_NEXT  = 2;
  localparam int TX_THR_LO = 8;
  localparam int RX_THR_LO = 4;

  function automatic logic [THR_W-1:0] tx_thr_bytes(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'(TX_MAX_CODE)) ? 3'(TX_MAX_CODE) : code;
    return THR_W'((int'(c) + 1) * TX_UNIT);
  endfunction

  function automatic logic [THR_W-1:0] rx_thr_bytes(input logic [1:0] code);
    return THR_W'((int'(code) + 1) * RX_UNIT);
  endfunction
endpackage

// File: rtl/frc_ctl_reg.sv
module frc_ctl_reg
  import frc_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             run,
  output logic             sf,
  output logic             nxt,
  output logic [2:0]       thr
);
  logic       en_q;
  logic       start_q;
  logic       w_nxt;
  logic [2:0] w_thr;

  generate
    if (IS_TX) begin : g_tx
      assign w_thr = wdata[TX_THR_LO +: 3];
      assign w_nxt = wdata[B_NEXT];
      assign rdata = {start_q, en_q, 19'b0, thr, 5'b0, nxt, sf, 1'b0};
    end else begin : g_rx
      assign w_thr = {1'b0, wdata[RX_THR_LO +: 2]};
      assign w_nxt = 1'b0;
      assign rdata = {start_q, en_q, 24'b0, thr[1:0], 2'b0, sf, 1'b0};
    end
  endgenerate

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      run     <= 1'b0;
      sf      <= 1'b0;
      nxt     <= 1'b0;
      thr     <= 3'd0;
    end else if (we) begin
      en_q    <= wdata[B_EN];
      start_q <= wdata[B_START];
      run     <= wdata[B_EN] & (wdata[B_START] | run);
      sf      <= wdata[B_SF];
      nxt     <= w_nxt;
      thr     <= w_thr;
    end else begin
      start_q <= 1'b0;
    end
  end

  // R3: start bit reads back for one cycle only
  a_r3_start_self_clear: assert property (@(posedge clk) disable iff (rst)
    (start_q && !we) |=> !start_q);
  // R4: a running direction always has its enable set
  a_r4_run_needs_en: assert property (@(posedge clk) disable iff (rst)
    run |-> en_q);
endmodule

// File: rtl/frc_tx_path.sv
module frc_tx_path
  import frc_pkg::*;
#(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             sf_i,
  input  logic             nxt_i,
  input  logic [2:0]       thr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             eof_i,
  input  logic             done_i,
  input  logic             rd_req_i,
  input  logic             empty_i,
  output logic             release_o,
  output logic             underflow_o
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] inflight;
  logic [THR_W-1:0] thr_bytes;
  logic             ready;
  logic             cap;
  logic             rel_d;
  logic             drop;
  logic             uf_d;

  assign thr_bytes = tx_thr_bytes(thr_i);
  assign ready = sf_i ? eof_i : (eof_i || (level_i >= LVL_W'(thr_bytes)));
  assign cap   = (inflight == '0) || (nxt_i && inflight == CNT_W'(1));
  assign rel_d = run_i && ready && cap;
  assign drop  = done_i && (inflight != '0);
  assign uf_d  = rd_req_i && empty_i && (inflight != '0) && !done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight    <= '0;
      release_o   <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      inflight    <= inflight + CNT_W'(rel_d) - CNT_W'(drop);
      release_o   <= rel_d;
      underflow_o <= uf_d;
    end
  end

  // R4: no release without a running direction
  a_r4_tx_needs_run: assert property (@(posedge clk) disable iff (rst)
    release_o |-> $past(run_i));
  // R5: whole-frame mode waits for the frame end
  a_r5_tx_sf_waits_eof: assert property (@(posedge clk) disable iff (rst)
    (release_o && $past(sf_i)) |-> $past(eof_i));
  // R8: without next-frame, release only from an empty pipeline
  a_r8_tx_single: assert property (@(posedge clk) disable iff (rst)
    (release_o && !$past(nxt_i)) |-> ($past(inflight) == '0));
  // R12: underflow only after an empty-FIFO request
  a_r12_uf_cause: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> $past(rd_req_i && empty_i));
endmodule

// File: rtl/frc_rx_path.sv
module frc_rx_path
  import frc_pkg::*;
#(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             sf_i,
  input  logic [1:0]       thr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             eof_i,
  input  logic             done_i,
  input  logic             wr_i,
  input  logic             full_i,
  output logic             release_o,
  output logic             overflow_o
);
  logic [THR_W-1:0] thr_bytes;
  logic             busy;
  logic             ready;
  logic             rel_d;

  assign thr_bytes = rx_thr_bytes(thr_i);
  assign ready = sf_i ? eof_i : (eof_i || (level_i >= LVL_W'(thr_bytes)));
  assign rel_d = run_i && ready && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      release_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      if (rel_d)       busy <= 1'b1;
      else if (done_i) busy <= 1'b0;
      release_o  <= rel_d;
      overflow_o <= wr_i && full_i;
    end
  end

  // R11: one receive frame in flight at a time
  a_r11_rx_one_frame: assert property (@(posedge clk) disable iff (rst)
    release_o |-> !$past(busy));
  // R9: whole-frame mode waits for the frame end
  a_r9_rx_sf_waits_eof: assert property (@(posedge clk) disable iff (rst)
    (release_o && $past(sf_i)) |-> $past(eof_i));
  // R13: overflow only after a write into a full FIFO
  a_r13_of_cause: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(wr_i && full_i));
endmodule

// File: rtl/frc_release_ctrl.sv
module frc_release_ctrl
  import frc_pkg::*;
#(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_ctl_we,
  input  logic [31:0]      tx_ctl_wdata,
  output logic [31:0]      tx_ctl_rdata,
  input  logic             rx_ctl_we,
  input  logic [31:0]      rx_ctl_wdata,
  output logic [31:0]      rx_ctl_rdata,
  input  logic [LVL_W-1:0] tx_head_level,
  input  logic             tx_head_eof,
  input  logic             tx_frame_done,
  input  logic             tx_rd_req,
  input  logic             tx_empty,
  output logic             tx_release,
  output logic             tx_underflow,
  input  logic [LVL_W-1:0] rx_head_level,
  input  logic             rx_head_eof,
  input  logic             rx_frame_done,
  input  logic             rx_wr,
  input  logic             rx_full,
  output logic             rx_release,
  output logic             rx_overflow
);
  logic       tx_run, tx_sf, tx_nxt;
  logic [2:0] tx_thr;
  logic       rx_run, rx_sf, rx_nxt;
  logic [2:0] rx_thr;
  logic       unused_rx;

  assign unused_rx = ^{rx_nxt, rx_thr[2]};

  frc_ctl_reg #(.IS_TX(1'b1)) i_tx_ctl (
    .clk(clk), .rst(rst), .we(tx_ctl_we), .wdata(tx_ctl_wdata),
    .rdata(tx_ctl_rdata), .run(tx_run), .sf(tx_sf), .nxt(tx_nxt), .thr(tx_thr)
  );

  frc_ctl_reg #(.IS_TX(1'b0)) i_rx_ctl (
    .clk(clk), .rst(rst), .we(rx_ctl_we), .wdata(rx_ctl_wdata),
    .rdata(rx_ctl_rdata), .run(rx_run), .sf(rx_sf), .nxt(rx_nxt), .thr(rx_thr)
  );

  frc_tx_path #(.LVL_W(LVL_W)) i_tx_path (
    .clk(clk), .rst(rst), .run_i(tx_run), .sf_i(tx_sf), .nxt_i(tx_nxt),
    .thr_i(tx_thr), .level_i(tx_head_level), .eof_i(tx_head_eof),
    .done_i(tx_frame_done), .rd_req_i(tx_rd_req), .empty_i(tx_empty),
    .release_o(tx_release), .underflow_o(tx_underflow)
  );

  frc_rx_path #(.LVL_W(LVL_W)) i_rx_path (
    .clk(clk), .rst(rst), .run_i(rx_run), .sf_i(rx_sf), .thr_i(rx_thr[1:0]),
    .level_i(rx_head_level), .eof_i(rx_head_eof), .done_i(rx_frame_done),
    .wr_i(rx_wr), .full_i(rx_full),
    .release_o(rx_release), .overflow_o(rx_overflow)
  );

  // R1: nothing fires in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !(tx_release || rx_release || tx_underflow || rx_overflow));
endmodule

// File: tb/test_frc_release_ctrl.sv
module test_frc_release_ctrl;
  localparam int LVL_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tx_ctl_we = 1'b0, rx_ctl_we = 1'b0;
  logic [31:0]      tx_ctl_wdata = '0, rx_ctl_wdata = '0;
  logic [31:0]      tx_ctl_rdata, rx_ctl_rdata;
  logic [LVL_W-1:0] tx_lvl = '0, rx_lvl = '0;
  logic             tx_eof = 0, tx_done = 0, tx_rd = 0, tx_emp = 0;
  logic             rx_eof = 0, rx_done = 0, rx_wr = 0, rx_full = 0;
  logic             tx_release, tx_underflow, rx_release, rx_overflow;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    tr; bit rr; bit uf; bit ov;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  frc_release_ctrl #(.LVL_W(LVL_W)) i_frc_release_ctrl (
    .clk(clk), .rst(rst),
    .tx_ctl_we(tx_ctl_we), .tx_ctl_wdata(tx_ctl_wdata), .tx_ctl_rdata(tx_ctl_rdata),
    .rx_ctl_we(rx_ctl_we), .rx_ctl_wdata(rx_ctl_wdata), .rx_ctl_rdata(rx_ctl_rdata),
    .tx_head_level(tx_lvl), .tx_head_eof(tx_eof), .tx_frame_done(tx_done),
    .tx_rd_req(tx_rd), .tx_empty(tx_emp),
    .tx_release(tx_release), .tx_underflow(tx_underflow),
    .rx_head_level(rx_lvl), .rx_head_eof(rx_eof), .rx_frame_done(rx_done),
    .rx_wr(rx_wr), .rx_full(rx_full),
    .rx_release(rx_release), .rx_overflow(rx_overflow)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per clock edge and compares
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "tx_release",   32'(tx_release),   32'(e.tr));
      cmp(e.tag, "rx_release",   32'(rx_release),   32'(e.rr));
      cmp(e.tag, "tx_underflow", 32'(tx_underflow), 32'(e.uf));
      cmp(e.tag, "rx_overflow",  32'(rx_overflow),  32'(e.ov));
    end
  end

  // driver: inputs are already set; queue the expectation for the next edge
  task automatic tick(bit tr, bit rr, bit uf, bit ov, string tag);
    exp_t e;
    e.tr = tr; e.rr = rr; e.uf = uf; e.ov = ov; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr_tx(logic [31:0] d);
    tx_ctl_we = 1'b1; tx_ctl_wdata = d;
    @(negedge clk);
    tx_ctl_we = 1'b0;
  endtask

  task automatic wr_rx(logic [31:0] d);
    rx_ctl_we = 1'b1; rx_ctl_wdata = d;
    @(negedge clk);
    rx_ctl_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cmp("R1", "outs", {28'b0, tx_release, rx_release, tx_underflow, rx_overflow}, 32'h0);
    cmp("R1", "tx_rdata", tx_ctl_rdata, 32'h0);
    cmp("R1", "rx_rdata", rx_ctl_rdata, 32'h0);

    // R4: nothing while not running, even with enable alone
    tx_eof = 1; rx_eof = 1;
    tick(0, 0, 0, 0, "R4 idle");
    tx_eof = 0; rx_eof = 0;
    wr_tx(32'h4000_0000); wr_rx(32'h4000_0000);
    tx_eof = 1; rx_eof = 1;
    tick(0, 0, 0, 0, "R4 enable without start");
    tx_eof = 0; rx_eof = 0;

    // R2 readback masking
    wr_tx(32'h7FFF_FFFF);
    cmp("R2", "tx_rdata", tx_ctl_rdata, 32'h4000_0706);
    wr_rx(32'h7FFF_FFFF);
    cmp("R2", "rx_rdata", rx_ctl_rdata, 32'h4000_0032);

    // R3 start self-clear, whole-frame mode on both sides
    wr_tx(32'hC000_0002);
    cmp("R3", "tx start set", tx_ctl_rdata, 32'hC000_0002);
    @(negedge clk);
    cmp("R3", "tx start clear", tx_ctl_rdata, 32'h4000_0002);
    wr_rx(32'hC000_0002);
    cmp("R3", "rx start set", rx_ctl_rdata, 32'hC000_0002);
    @(negedge clk);
    cmp("R3", "rx start clear", rx_ctl_rdata, 32'h4000_0002);

    // R5 transmit whole-frame mode
    tx_lvl = 12'd300;
    tick(0, 0, 0, 0, "R5 level only");
    tick(0, 0, 0, 0, "R5 level only");
    tx_eof = 1;
    tick(1, 0, 0, 0, "R5 frame end");
    tx_eof = 0; tx_lvl = 0;
    tick(0, 0, 0, 0, "R5 after release");
    // R8 single frame in flight
    tx_eof = 1;
    tick(0, 0, 0, 0, "R8 slot busy");
    tx_done = 1;
    tick(0, 0, 0, 0, "R8 done same cycle");
    tx_done = 0;
    tick(1, 0, 0, 0, "R8 slot freed");
    tx_eof = 0;
    wr_tx(32'hC000_0006);
    tx_eof = 1;
    tick(1, 0, 0, 0, "R8 second frame with next-frame");
    tick(0, 0, 0, 0, "R8 third frame blocked");
    tx_eof = 0; tx_done = 1;
    tick(0, 0, 0, 0, "R8 drain");
    tick(0, 0, 0, 0, "R8 drain");
    tx_done = 0;

    // R6 transmit thresholds
    for (int c = 0; c < 8; c++) begin
      int t;
      t = ((c > 3) ? 4 : c + 1) * 64;
      wr_tx(32'h4000_0000 | (32'(c) << 8));
      tx_lvl = LVL_W'(t - 1);
      tick(0, 0, 0, 0, $sformatf("R6 code %0d below", c));
      tx_lvl = LVL_W'(t);
      tick(1, 0, 0, 0, $sformatf("R6 code %0d at threshold", c));
      tx_lvl = 0; tx_done = 1;
      tick(0, 0, 0, 0, "R6 drain");
      tx_done = 0;
    end

    // R7 transmit frame end below threshold (code 3 still active)
    tx_lvl = 12'd5; tx_eof = 1;
    tick(1, 0, 0, 0, "R7 tx short frame");
    tx_lvl = 0; tx_eof = 0; tx_done = 1;
    tick(0, 0, 0, 0, "R7 drain");
    tx_done = 0;

    // R12 underflow
    tx_eof = 1;
    tick(1, 0, 0, 0, "R12 setup release");
    tx_eof = 0; tx_rd = 1; tx_emp = 1;
    tick(0, 0, 1, 0, "R12 empty read in frame");
    tx_emp = 0;
    tick(0, 0, 0, 0, "R12 non-empty read");
    tx_emp = 1; tx_done = 1;
    tick(0, 0, 0, 0, "R12 frame ends");
    tx_done = 0;
    tick(0, 0, 0, 0, "R12 no frame in flight");
    tx_rd = 0; tx_emp = 0;

    // R4 stop by clearing enable
    wr_tx(32'h0000_0000);
    tx_eof = 1;
    tick(0, 0, 0, 0, "R4 tx stopped");
    tx_eof = 0;

    // R9 receive whole-frame mode
    rx_lvl = 12'd200;
    tick(0, 0, 0, 0, "R9 level only");
    rx_eof = 1;
    tick(0, 1, 0, 0, "R9 frame end");
    // R11 one frame in flight
    tick(0, 0, 0, 0, "R11 busy");
    rx_done = 1;
    tick(0, 0, 0, 0, "R11 done same cycle");
    rx_done = 0;
    tick(0, 1, 0, 0, "R11 freed");
    rx_eof = 0; rx_lvl = 0; rx_done = 1;
    tick(0, 0, 0, 0, "R11 drain");
    rx_done = 0;

    // R10 receive thresholds
    for (int c = 0; c < 4; c++) begin
      int t;
      t = (c + 1) * 32;
      wr_rx(32'h4000_0000 | (32'(c) << 4));
      rx_lvl = LVL_W'(t - 1);
      tick(0, 0, 0, 0, $sformatf("R10 code %0d below", c));
      rx_lvl = LVL_W'(t);
      tick(0, 1, 0, 0, $sformatf("R10 code %0d at threshold", c));
      rx_lvl = 0; rx_done = 1;
      tick(0, 0, 0, 0, "R10 drain");
      rx_done = 0;
    end

    // R7 receive frame end below threshold
    rx_lvl = 12'd1; rx_eof = 1;
    tick(0, 1, 0, 0, "R7 rx short frame");
    rx_lvl = 0; rx_eof = 0; rx_done = 1;
    tick(0, 0, 0, 0, "R7 drain");
    rx_done = 0;

    // R13 overflow
    rx_wr = 1; rx_full = 1;
    tick(0, 0, 0, 1, "R13 write into full");
    rx_full = 0;
    tick(0, 0, 0, 0, "R13 write not full");
    rx_wr = 0; rx_full = 1;
    tick(0, 0, 0, 0, "R13 full no write");
    rx_full = 0;

    // R4 receive stop
    wr_rx(32'h0000_0000);
    rx_eof = 1;
    tick(0, 0, 0, 0, "R4 rx stopped");
    rx_eof = 0;

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule